// File: doc/BRIEF.md
# Multi-Queue Shared-Storage FIFO

This block keeps up to sixteen independent first-in first-out queues inside one storage array. A single write port accepts one word per clock and routes it to the queue named by a write-side queue number. A single read port presents the head word of the queue named by a read-side queue number. The two sides pick their queues independently, so one queue can be filled while another is drained, and a write and a read can both complete in every cycle.

Storage is split into equal segments. Each queue is given a first segment and a segment count. These settings are taken while reset is high and stay fixed until the next reset. A queue's pointers wrap inside its own segments. The read side works as first-word-fall-through: the head word is already on `rd_data` before any read strobe, and a read strobe moves on to the next word. Empty and full status are reported for the queue that each side currently addresses.

Top module: `mq_fifo`

## Requirements
- R1: While `rst` is high on a clock edge, every queue's contents are discarded and `rd_empty` becomes 1. After reset, every enabled queue reports `wr_full` = 0.
- R2: Words written to a queue through `wr_q` are returned in write order on `rd_data` when `rd_q` selects that queue. Writes and reads aimed at other queues do not disturb this order.
- R3: A word written to an empty queue that `rd_q` selects is valid on `rd_data`, with `rd_empty` = 0, one cycle after the write edge, without any `rd_en`. An accepted `rd_en` moves the output to the next word, or sets `rd_empty` when no word is left.
- R4: A write to one queue and a read from a different queue both complete in the same cycle. This holds on every cycle of a sustained run, with no idle cycles.
- R5: A queue holds exactly (segment count × SEG_WORDS) words. `wr_full` goes to 1 when that many words are stored. Data stays in order after its pointers wrap inside its region.
- R6: A write to a full queue is ignored. That queue's stored words and order are unchanged, and so are those of every other queue.
- R7: A read strobe while the presented queue is empty is ignored. A later write to that queue appears correctly as its head.
- R8: In a cycle where `rd_q` differs from the queue presented in the previous cycle, `rd_en` is ignored. In the next cycle, `rd_data` and `rd_empty` show the newly selected queue.
- R9: A queue is disabled if its index is not below `cfg_qcount`, if its segment count is 0, or if its region runs past the last segment. A disabled queue reports `wr_full` = 1 and `rd_empty` = 1, and writes to it are ignored.
- R10: The configuration inputs are captured only while `rst` is high. A new reset with a new configuration re-partitions the storage; for example, sixteen queues of one segment each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while it is high |
| cfg_qcount | input | $clog2(NUM_Q+1) | Number of enabled queues |
| cfg_base | input | NUM_Q*$clog2(NUM_SEG) | First segment of each queue, queue i in slice i |
| cfg_nseg | input | NUM_Q*$clog2(NUM_SEG+1) | Segment count of each queue, queue i in slice i |
| wr_en | input | 1 | Write strobe |
| wr_q | input | $clog2(NUM_Q) | Queue number for the write side |
| wr_data | input | DATA_W | Write word |
| wr_full | output | 1 | Queue addressed by `wr_q` cannot accept a word |
| rd_en | input | 1 | Read strobe; advances the presented queue |
| rd_q | input | $clog2(NUM_Q) | Queue number for the read side |
| rd_data | output | DATA_W | Head word of the presented queue |
| rd_empty | output | 1 | Presented queue holds no word |

## Verification
Directed runs cover several cases:
- A single word into an empty queue, which exposes the fall-through path and the same-address bypass.
- A full fill, an overflow attempt and a drain of a one-segment queue, which locate the capacity boundary and the wrap.
- Cross-queue traffic with a write and a read every cycle, which separates the write demultiplexer from the read multiplexer.
- `rd_q` toggling with `rd_en` held high, which shows whether reads are held off on a switch.

A long constrained-random run then mixes writes to enabled and disabled queues with occasional read-queue changes. This catches pointer or count corruption that only shows up across queues. A second reset with a different partition confirms that the configuration is captured again.

// File: rtl/mqf_pkg.sv
package mqf_pkg;

    typedef struct packed {
        logic empty;
        logic full;
    } qflag_t;

    typedef enum logic [1:0] {
        RD_HOLD   = 2'd0,
        RD_POP    = 2'd1,
        RD_SWITCH = 2'd2
    } rd_act_e;

    // next offset inside a region of cap words, wrapping to zero
    function automatic int ring_next(input int off, input int cap);
        return (off + 1 >= cap) ? 0 : off + 1;
    endfunction

    // region fits inside the array and is not empty
    function automatic logic region_ok(input int base, input int nseg, input int total);
        return (nseg != 0) && (base + nseg <= total);
    endfunction

endpackage

// File: rtl/mqf_store.sv
module mqf_store #(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // registered read; a write landing on the read address is forwarded
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= (we && (waddr == raddr)) ? wdata : mem[raddr];
    end

endmodule

// File: rtl/mqf_queue_ctrl.sv
module mqf_queue_ctrl
    import mqf_pkg::*;
#(
    parameter int SEG_WORDS = 16,
    parameter int NUM_SEG   = 16,
    parameter int ADDR_W    = $clog2(NUM_SEG * SEG_WORDS),
    parameter int SEGI_W    = $clog2(NUM_SEG),
    parameter int SEGC_W    = $clog2(NUM_SEG + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic [SEGI_W-1:0] cfg_base,
    input  logic [SEGC_W-1:0] cfg_nseg,
    input  logic              push,
    input  logic              pop,
    output qflag_t            flags,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] head_nxt,
    output logic              empty_nxt
);

    localparam int CNT_W  = ADDR_W + 1;
    localparam int SEG_SH = $clog2(SEG_WORDS);

    logic              live;
    logic [ADDR_W-1:0] base_w;
    logic [CNT_W-1:0]  cap;
    logic [ADDR_W-1:0] wr_off, rd_off, wr_off_inc, rd_off_inc;
    logic [CNT_W-1:0]  cnt, cnt_nxt;

    always_comb begin
        wr_off_inc = ADDR_W'(ring_next(int'(wr_off), int'(cap)));
        rd_off_inc = ADDR_W'(ring_next(int'(rd_off), int'(cap)));
        unique case ({push, pop})
            2'b10:   cnt_nxt = cnt + CNT_W'(1);
            2'b01:   cnt_nxt = cnt - CNT_W'(1);
            default: cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live   <= cfg_enable && region_ok(int'(cfg_base), int'(cfg_nseg), NUM_SEG);
            base_w <= ADDR_W'(cfg_base) << SEG_SH;
            cap    <= CNT_W'(cfg_nseg) << SEG_SH;
            wr_off <= '0;
            rd_off <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_off <= wr_off_inc;
            if (pop)  rd_off <= rd_off_inc;
            cnt <= cnt_nxt;
        end
    end

    assign flags.empty = !live || (cnt == '0);
    assign flags.full  = !live || (cnt == cap);
    assign wr_addr     = base_w + wr_off;
    assign head_nxt    = base_w + (pop ? rd_off_inc : rd_off);
    assign empty_nxt   = !live || (cnt_nxt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= cap);                                                   // R5
    AST_PUSH_GATED: assert property (@(posedge clk) disable iff (rst)
        push |-> !flags.full);                                         // R6
    AST_POP_GATED: assert property (@(posedge clk) disable iff (rst)
        pop |-> !flags.empty);                                         // R7
    AST_DEAD_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !live |-> (cnt == '0));                                        // R9
    AST_CNT_UP: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (cnt == $past(cnt) + CNT_W'(1)));           // R2

endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
    import mqf_pkg::*;
#(
    parameter int NUM_Q     = 16,
    parameter int DATA_W    = 36,
    parameter int SEG_WORDS = 16,
    parameter int NUM_SEG   = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [$clog2(NUM_Q+1)-1:0]        cfg_qcount,
    input  logic [NUM_Q*$clog2(NUM_SEG)-1:0]  cfg_base,
    input  logic [NUM_Q*$clog2(NUM_SEG+1)-1:0] cfg_nseg,
    input  logic                              wr_en,
    input  logic [$clog2(NUM_Q)-1:0]          wr_q,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic                              wr_full,
    input  logic                              rd_en,
    input  logic [$clog2(NUM_Q)-1:0]          rd_q,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              rd_empty
);

    localparam int QW     = $clog2(NUM_Q);
    localparam int QC_W   = $clog2(NUM_Q + 1);
    localparam int SEGI_W = $clog2(NUM_SEG);
    localparam int SEGC_W = $clog2(NUM_SEG + 1);
    localparam int DEPTH  = NUM_SEG * SEG_WORDS;
    localparam int ADDR_W = $clog2(DEPTH);

    qflag_t            flg       [NUM_Q];
    logic [ADDR_W-1:0] wr_addr_a [NUM_Q];
    logic [ADDR_W-1:0] head_nxt_a[NUM_Q];
    logic [NUM_Q-1:0]  empty_nxt_a;
    logic [NUM_Q-1:0]  push, pop;

    logic [QW-1:0]     rd_q_r;
    logic              rd_empty_r;
    logic              wr_q_ok;
    rd_act_e           rd_act;

    assign wr_q_ok = (int'(wr_q) < NUM_Q);

    // read side decision: a queue switch holds off the strobe
    always_comb begin
        if (rd_q != rd_q_r)                  rd_act = RD_SWITCH;
        else if (rd_en && !flg[rd_q_r].empty) rd_act = RD_POP;
        else                                  rd_act = RD_HOLD;
    end

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        assign push[i] = wr_en && wr_q_ok && (wr_q == QW'(i)) && !flg[i].full;
        assign pop[i]  = (rd_act == RD_POP) && (rd_q_r == QW'(i));

        mqf_queue_ctrl #(
            .SEG_WORDS (SEG_WORDS),
            .NUM_SEG   (NUM_SEG),
            .ADDR_W    (ADDR_W),
            .SEGI_W    (SEGI_W),
            .SEGC_W    (SEGC_W)
        ) u_ctrl (
            .clk        (clk),
            .rst        (rst),
            .cfg_enable (QC_W'(i) < cfg_qcount),
            .cfg_base   (cfg_base[i*SEGI_W +: SEGI_W]),
            .cfg_nseg   (cfg_nseg[i*SEGC_W +: SEGC_W]),
            .push       (push[i]),
            .pop        (pop[i]),
            .flags      (flg[i]),
            .wr_addr    (wr_addr_a[i]),
            .head_nxt   (head_nxt_a[i]),
            .empty_nxt  (empty_nxt_a[i])
        );
    end

    mqf_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk   (clk),
        .we    (|push),
        .waddr (wr_addr_a[wr_q]),
        .wdata (wr_data),
        .raddr (head_nxt_a[rd_q]),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q_r     <= '0;
            rd_empty_r <= 1'b1;
        end else begin
            rd_q_r     <= rd_q;
            rd_empty_r <= empty_nxt_a[rd_q];
        end
    end

    assign wr_full  = wr_q_ok ? flg[wr_q].full : 1'b1;
    assign rd_empty = rd_empty_r;

    AST_SWITCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_q != rd_q_r) |-> (pop == '0));                             // R8
    AST_ONE_PUSH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(push));                                               // R2
    AST_ONE_POP: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pop));                                                // R4
    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
        ((|push) && (wr_q == rd_q)) |=> !rd_empty);                    // R3

endmodule

// File: tb/tb_mq_fifo.sv
module tb_mq_fifo;

    localparam int NQ = 16, DW = 36, SW = 16, NS = 16;
    localparam int SEGI_W = $clog2(NS), SEGC_W = $clog2(NS + 1);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                     rst = 1'b1;
    logic [4:0]               cfg_qcount;
    logic [NQ*SEGI_W-1:0]     cfg_base;
    logic [NQ*SEGC_W-1:0]     cfg_nseg;
    logic                     wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]               wr_q = '0, rd_q = '0;
    logic [DW-1:0]            wr_data = '0;
    logic                     wr_full, rd_empty;
    logic [DW-1:0]            rd_data;

    mq_fifo #(.NUM_Q(NQ), .DATA_W(DW), .SEG_WORDS(SW), .NUM_SEG(NS)) dut (
        .clk(clk), .rst(rst), .cfg_qcount(cfg_qcount), .cfg_base(cfg_base),
        .cfg_nseg(cfg_nseg), .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
        .wr_full(wr_full), .rd_en(rd_en), .rd_q(rd_q), .rd_data(rd_data),
        .rd_empty(rd_empty)
    );

    int n_chk = 0, n_err = 0;
    logic [DW-1:0] mq [NQ][NS*SW];
    int hd [NQ], ct [NQ], cap [NQ], base_a [NQ], nseg_a [NQ];
    int qcount, cur_rq;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_full(input int q);
        return (cap[q] == 0) || (ct[q] == cap[q]);
    endfunction

    function automatic bit m_empty(input int q);
        return (cap[q] == 0) || (ct[q] == 0);
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        logic [63:0] t;
        t = {$urandom, $urandom};
        return t[DW-1:0];
    endfunction

    task automatic cfg_apply();
        cfg_qcount = 5'(qcount);
        for (int i = 0; i < NQ; i++) begin
            cfg_base[i*SEGI_W +: SEGI_W] = SEGI_W'(base_a[i]);
            cfg_nseg[i*SEGC_W +: SEGC_W] = SEGC_W'(nseg_a[i]);
            cap[i] = (i < qcount && nseg_a[i] > 0 && base_a[i] + nseg_a[i] <= NS)
                     ? nseg_a[i] * SW : 0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_q = '0; rd_q = '0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < NQ; i++) begin hd[i] = 0; ct[i] = 0; end
        cur_rq = 0;
    endtask

    task automatic step(input bit wen, input int wq, input logic [DW-1:0] wd,
                        input bit ren, input int rq, input string req);
        bit psh, pp;
        wr_en = wen; wr_q = 4'(wq); wr_data = wd; rd_en = ren; rd_q = 4'(rq);
        #2;
        chk(wr_full === m_full(wq), req, "wr_full", longint'(wr_full), longint'(m_full(wq)));
        psh = wen && !m_full(wq);
        pp  = ren && (rq == cur_rq) && !m_empty(rq);
        @(posedge clk);
        #1;
        if (psh) begin
            mq[wq][(hd[wq] + ct[wq]) % cap[wq]] = wd;
            ct[wq]++;
        end
        if (pp) begin
            hd[rq] = (hd[rq] + 1) % cap[rq];
            ct[rq]--;
        end
        cur_rq = rq;
        chk(rd_empty === m_empty(rq), req, "rd_empty", longint'(rd_empty), longint'(m_empty(rq)));
        if (!m_empty(rq))
            chk(rd_data === mq[rq][hd[rq]], req, "rd_data",
                longint'(rd_data), longint'(mq[rq][hd[rq]]));
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        // partition A: five enabled queues of 1, 2, 4, 1 and 8 segments
        qcount = 5;
        for (int i = 0; i < NQ; i++) begin base_a[i] = 0; nseg_a[i] = 1; end
        base_a[1] = 1; nseg_a[1] = 2;
        base_a[2] = 3; nseg_a[2] = 4;
        base_a[3] = 7; nseg_a[3] = 1;
        base_a[4] = 8; nseg_a[4] = 8;
        cfg_apply();
        do_reset();

        // R1: reset state
        chk(rd_empty === 1'b1, "R1", "rd_empty after reset", longint'(rd_empty), 1);
        for (int q = 0; q < 6; q++) begin
            wr_q = 4'(q);
            #1;
            chk(wr_full === m_full(q), (q < 5) ? "R1" : "R9", "wr_full after reset",
                longint'(wr_full), longint'(m_full(q)));
        end
        @(posedge clk); #1;

        // R3: fall-through of a single word, then pop
        step(1, 0, rnd_word(), 0, 0, "R3");
        step(0, 0, '0, 1, 0, "R3");
        step(0, 0, '0, 0, 0, "R3");

        // R5: fill a one-segment queue to capacity
        for (int k = 0; k < SW; k++) step(1, 3, rnd_word(), 0, 0, "R5");
        // R6: overflow attempt is ignored
        step(1, 3, 36'hBAD_BAD_BAD, 0, 0, "R6");
        step(1, 3, 36'h0DE_AD0_BEE, 0, 0, "R6");
        // R8: switch with strobe held high, strobe ignored
        step(0, 0, '0, 1, 3, "R8");
        for (int k = 0; k < SW; k++) step(0, 0, '0, 1, 3, "R5");
        // R5: wrap with simultaneous write and read on the same queue
        for (int k = 0; k < 3 * SW; k++) step(1, 3, rnd_word(), (k > 0), 3, "R5");

        // R4: cross-queue traffic every cycle
        for (int k = 0; k < 20; k++) step(1, 2, rnd_word(), 0, 2, "R4");
        for (int k = 0; k < 20; k++) step(1, 1, rnd_word(), 1, 2, "R4");
        step(1, 2, rnd_word(), 0, 1, "R4");
        for (int k = 0; k < 20; k++) step(1, 2, rnd_word(), 1, 1, "R4");

        // R7: strobe on an empty queue, then a fresh word
        step(0, 0, '0, 0, 0, "R7");
        for (int k = 0; k < 4; k++) step(0, 0, '0, 1, 0, "R7");
        step(1, 0, rnd_word(), 1, 0, "R7");
        step(0, 0, '0, 0, 0, "R7");

        // R8: rapid toggling with strobe high holds every read off
        for (int k = 0; k < 8; k++) step(0, 0, '0, 1, (k % 2) ? 2 : 0, "R8");

        // R9: queues beyond the enabled count
        step(1, 5, rnd_word(), 0, 5, "R9");
        step(1, 6, rnd_word(), 1, 5, "R9");

        // R2: constrained random mix
        for (int k = 0; k < 3000; k++) begin
            int wq, rq;
            wq = $urandom % 7;
            rq = (($urandom % 8) == 0) ? int'($urandom % 7) : cur_rq;
            step(($urandom % 10) < 7, wq, rnd_word(), ($urandom % 10) < 6, rq, "R2");
        end

        // R10: re-partition into sixteen one-segment queues
        qcount = 16;
        for (int i = 0; i < NQ; i++) begin base_a[i] = i; nseg_a[i] = 1; end
        cfg_apply();
        do_reset();
        chk(rd_empty === 1'b1, "R10", "rd_empty after second reset", longint'(rd_empty), 1);
        step(0, 15, '0, 0, 15, "R10");
        for (int k = 0; k < SW; k++) step(1, 15, rnd_word(), 0, 15, "R10");
        step(1, 15, rnd_word(), 0, 15, "R10");
        for (int k = 0; k < 6; k++) step(1, 9, rnd_word(), 1, 15, "R10");

        report();
    end

endmodule